// File: doc/BRIEF.md
# Page-Mode Parallel Memory Host Controller

This block sits between a synchronous request port and the pins of an asynchronous word-wide nonvolatile memory. The memory is arranged in rows of four 16-bit words. Once a row is open, the controller moves between its columns without raising chip enable. A read request or a write request carries a 17-bit word address, a burst length of one to four words, a two-bit byte mask and up to four words of write data. The controller turns the request into chip enable, write enable, output enable, byte lane enable, address and data drive sequences. For reads it returns each word with a one-cycle valid strobe.

After the first word in a row, every further word in the same row is a column-only access, which is shorter than the first access. A burst that runs past column 3 is split. Chip enable goes high, precharge is waited out, and the burst carries on at column 0 of the next row. The row address wraps from the top of the array to row 0. Writes are controlled by chip enable: write enable falls one cycle before chip enable. Output enable stays high for the whole write, and the controller drives the data bus only while write enable is low. Every burst ends with a full precharge before the next request can be taken. All timings are parameters counted in clock cycles.

Top module: `pmem_host_ctrl`

## Requirements
- R1: In reset and right after it, chip enable, write enable, output enable and both byte lane enables are high, the data drive enable is low, ready is high and read valid is low.
- R2: For a read, the first word of each row is returned T_ACC cycles after the cycle in which chip enable fell, with output enable low for that whole interval.
- R3: Within an open row, each later word of a read burst is returned T_PAGE cycles after the previous one. Chip enable stays low and address bits 16 down to 2 stay unchanged.
- R4: A burst that passes column 3 raises chip enable for at least T_PRE cycles and then resumes at column 0 of the next row, with the row address wrapping from the top row to row 0.
- R5: After the last word of any burst, chip enable stays high for T_PRE cycles before ready returns high.
- R6: On a write, write enable is already low in the cycle before chip enable falls. Output enable stays high while write enable is low, and the data drive enable is high only while write enable is low.
- R7: A write burst gives exactly one write-enable low pulse per word. The first pulse in each row includes T_ACC cycles with chip enable low, and every later pulse is at least T_WP cycles long.
- R8: The driven write data does not change while write enable stays low.
- R9: Byte mask bit 1 selects the upper byte (bits 15:8) and bit 0 the lower byte (bits 7:0). A write changes only the selected bytes, and a read returns zero in unselected byte lanes.
- R10: Ready is low from the cycle after a request is accepted until the burst, including its final precharge, is done. A request presented while ready is low is not taken.
- R11: The length field carries the word count minus one (0 = one word, 3 = four words). Write data word k is taken from bits 16k+15 down to 16k, and word k goes to address start + k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this cycle if valid |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Start word address |
| req_len | input | 2 | Word count minus one |
| req_bmask | input | 2 | Byte lanes selected, bit 1 upper, bit 0 lower |
| req_wdata | input | 4*DW | Write data, word k in slice k |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DW | Read word, unselected lanes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper byte lane enable, active low |
| mem_lb_n | output | 1 | Lower byte lane enable, active low |
| mem_addr | output | AW | Memory word address |
| mem_dq_out | output | DW | Data to drive onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DW | Data read from the memory bus |

## Verification
The bench uses the default timings: a full access of 6, a page access of 2, a precharge of 4, a write pulse of 3 and a data setup of 1 cycle. With these values a first-in-row word, a column-only word and a row-crossing word each arrive at a different cycle offset, so the cycle on which each read word appears shows which path was taken. The 17-bit address lets a short burst started two words below the top of the array wrap to row 0. Four-word bursts started at column 2 reach the row split in a single request.

// File: rtl/pmem_host_ctrl.sv
module pmem_host_ctrl #(
  parameter int AW     = 17,
  parameter int DW     = 16,
  parameter int T_ACC  = 6,
  parameter int T_PAGE = 2,
  parameter int T_PRE  = 4,
  parameter int T_WP   = 3,
  parameter int T_SU   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_len,
  input  logic [1:0]    req_bmask,
  input  logic [4*DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int RW     = AW - 2;
  localparam int BW     = DW / 2;
  localparam int ACC_W  = (T_ACC > T_SU) ? T_ACC : T_SU;
  localparam int WP_EFF = (T_WP > T_SU) ? T_WP : T_SU;
  localparam int CW     = $clog2(ACC_W + T_PAGE + T_PRE + WP_EFF + 2);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_ACC, S_GAP, S_COL, S_PRE} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic            wr, more;
  logic [RW-1:0]   row;
  logic [1:0]      col, idx, left, bm;
  logic [4*DW-1:0] wd;

  wire act   = (st == S_ACC) || (st == S_GAP) || (st == S_COL);
  wire xfer  = (st == S_ACC) || (st == S_COL);
  wire drive = act || (st == S_WSET);

  assign req_ready  = (st == S_IDLE);
  assign mem_ce_n   = ~act;
  assign mem_we_n   = ~(wr && (xfer || st == S_WSET));
  assign mem_oe_n   = ~(!wr && xfer);
  assign mem_dq_oe  = ~mem_we_n;
  assign mem_ub_n   = ~(bm[1] && drive);
  assign mem_lb_n   = ~(bm[0] && drive);
  assign mem_addr   = {row, col};
  assign mem_dq_out = wd[int'(idx)*DW +: DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wr <= 1'b0; more <= 1'b0;
      row <= '0; col <= '0; idx <= '0; left <= '0; bm <= '0; wd <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr   <= req_write;
          row  <= req_addr[AW-1:2];
          col  <= req_addr[1:0];
          idx  <= '0;
          left <= req_len;
          bm   <= req_bmask;
          wd   <= req_wdata;
          st   <= req_write ? S_WSET : S_ACC;
          cnt  <= CW'(T_ACC - 1);
        end
        S_WSET: begin
          st  <= S_ACC;
          cnt <= CW'(ACC_W - 1);
        end
        S_ACC, S_COL: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            if (!wr) begin
              rd_valid <= 1'b1;
              rd_data  <= mem_dq_in & {{BW{bm[1]}}, {BW{bm[0]}}};
            end
            if (left == 2'd0) begin
              st <= S_PRE; more <= 1'b0; cnt <= CW'(T_PRE - 1);
            end else begin
              left <= left - 2'd1;
              idx  <= idx + 2'd1;
              if (col == 2'd3) begin
                row <= row + 1'b1; col <= 2'd0;
                st <= S_PRE; more <= 1'b1; cnt <= CW'(T_PRE - 1);
              end else begin
                col <= col + 2'd1;
                st  <= wr ? S_GAP : S_COL;
                cnt <= CW'(T_PAGE - 1);
              end
            end
          end
        end
        S_GAP: begin
          st  <= S_COL;
          cnt <= CW'(WP_EFF - 1);
        end
        S_PRE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (more) begin
            st  <= wr ? S_WSET : S_ACC;
            cnt <= CW'(T_ACC - 1);
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] ce_hi;
  always_ff @(posedge clk) begin
    if (!rst_n) ce_hi <= CW'(T_PRE);
    else if (!mem_ce_n) ce_hi <= '0;
    else if (ce_hi < CW'(T_PRE)) ce_hi <= ce_hi + 1'b1;
  end

  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> ce_hi >= CW'(T_PRE));
  assert_row_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr[AW-1:2]));
  assert_we_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) && !mem_we_n) |-> $past(!mem_we_n));
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n));
  assert_oe_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

endmodule

// File: tb/sim_pmem_host_ctrl.sv
module sim_pmem_host_ctrl;
  localparam int TA = 6, TP = 2, TPR = 4, TW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [1:0] req_len = '0, req_bmask = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [15:0] rd_data;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #4 clk = ~clk;

  pmem_host_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_bmask(req_bmask), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  int tests = 0, fails = 0;
  logic [15:0] mem [int];
  logic [15:0] shadow [int];

  int we_pulses = 0, ce_falls = 0, viol = 0, min_run = 99, we_run = 0;
  logic p_ce = 1'b1, p_we = 1'b1, p_ub = 1'b1, p_lb = 1'b1;
  logic [16:0] p_addr = '0;
  logic [15:0] p_dq = '0;

  always @(mem_addr or mem_ce_n or mem_oe_n or mem_ub_n or mem_lb_n) begin
    logic [15:0] w;
    w = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
    if (!mem_ce_n && !mem_oe_n)
      mem_dq_in = {mem_ub_n ? 8'hEE : w[15:8], mem_lb_n ? 8'hEE : w[7:0]};
    else
      mem_dq_in = 16'hDEAD;
  end

  always @(negedge clk) if (rst_n) begin
    if (!p_ce && !p_we && (mem_we_n || mem_ce_n)) begin
      logic [15:0] w;
      w = mem.exists(int'(p_addr)) ? mem[int'(p_addr)] : 16'h0000;
      if (!p_ub) w[15:8] = p_dq[15:8];
      if (!p_lb) w[7:0] = p_dq[7:0];
      mem[int'(p_addr)] = w;
    end
    if (!p_we && mem_we_n) begin
      we_pulses++;
      if (we_run < min_run) min_run = we_run;
    end
    we_run = mem_we_n ? 0 : we_run + 1;
    if (p_ce && !mem_ce_n) begin
      ce_falls++;
      if (!mem_we_n && p_we) viol++;
    end
    if (mem_dq_oe && (!mem_oe_n || mem_we_n)) viol++;
    if (!mem_we_n && !mem_oe_n) viol++;
    p_ce = mem_ce_n; p_we = mem_we_n; p_ub = mem_ub_n; p_lb = mem_lb_n;
    p_addr = mem_addr; p_dq = mem_dq_out;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit wr, input int addr, input int len,
                     input logic [1:0] mask, input logic [63:0] data,
                     input string req);
    int exp_t[4];
    int got_t[4];
    logic [15:0] got_d[4];
    int nrv = 0, k = 0, t = 0, rows = 0;
    logic [15:0] m;
    m = {{8{mask[1]}}, {8{mask[0]}}};
    for (int i = 0; i <= len; i++) begin
      int a;
      a = (addr + i) & 32'h1FFFF;
      if (i == 0 || (a & 3) == 0) begin
        rows++;
        t += (i > 0 ? TPR : 0) + (wr ? 1 : 0) + TA;
      end else t += wr ? 1 + TW : TP;
      exp_t[i] = t;
    end
    @(negedge clk);
    we_pulses = 0; ce_falls = 0; viol = 0; min_run = 99;
    req_valid = 1'b1; req_write = wr; req_addr = 17'(addr);
    req_len = 2'(len); req_bmask = mask; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", "ready after accept", int'(req_ready), 0);
    while (!req_ready && k < 200) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (rd_valid && nrv < 4) begin got_t[nrv] = k; got_d[nrv] = rd_data; nrv++; end
    end
    chk(k == exp_t[len] + TPR, "R5", {req, " ready return cycle"}, k, exp_t[len] + TPR);
    chk(ce_falls == rows, "R4", {req, " row opens"}, ce_falls, rows);
    chk(viol == 0, "R6", {req, " bus control violations"}, viol, 0);
    if (wr) begin
      chk(nrv == 0, "R11", {req, " read strobes on write"}, nrv, 0);
      chk(we_pulses == len + 1, "R7", {req, " write pulses"}, we_pulses, len + 1);
      chk(min_run >= TW, "R7", {req, " shortest write pulse"}, min_run, TW);
      for (int i = 0; i <= len; i++) begin
        int a;
        logic [15:0] o, d, got;
        a = (addr + i) & 32'h1FFFF;
        o = shadow.exists(a) ? shadow[a] : 16'h0000;
        d = data[i*16 +: 16];
        shadow[a] = (o & ~m) | (d & m);
        got = mem.exists(a) ? mem[a] : 16'h0000;
        chk(got == shadow[a], "R9", {req, " stored word"}, int'(got), int'(shadow[a]));
      end
    end else begin
      chk(nrv == len + 1, "R11", {req, " read word count"}, nrv, len + 1);
      for (int i = 0; i <= len && i < nrv; i++) begin
        int a;
        logic [15:0] e;
        a = (addr + i) & 32'h1FFFF;
        e = (shadow.exists(a) ? shadow[a] : 16'h0000) & m;
        chk(got_t[i] == exp_t[i], (i == 0) ? "R2" : "R3", {req, " word arrival cycle"},
            got_t[i], exp_t[i]);
        chk(got_d[i] == e, "R9", {req, " read word"}, int'(got_d[i]), int'(e));
      end
    end
  endtask

  task automatic t_reset();
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes high", 
        int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
    chk(mem_ub_n && mem_lb_n, "R1", "byte lanes high", int'({mem_ub_n, mem_lb_n}), 3);
    chk(!mem_dq_oe, "R1", "data drive", int'(mem_dq_oe), 0);
    chk(req_ready && !rd_valid, "R1", "ready/valid", int'({req_ready, rd_valid}), 2);
  endtask

  task automatic t_page_write();  run(1'b1, 32'h00100, 3, 2'b11, 64'h4444_3333_2222_1111, "R7 page write"); endtask
  task automatic t_page_read();   run(1'b0, 32'h00100, 3, 2'b11, 64'h0, "R3 page read"); endtask
  task automatic t_single_read(); run(1'b0, 32'h00102, 0, 2'b11, 64'h0, "R2 single read"); endtask
  task automatic t_mid_read();    run(1'b0, 32'h00101, 1, 2'b11, 64'h0, "R3 mid-row read"); endtask
  task automatic t_cross();
    run(1'b1, 32'h00206, 3, 2'b11, 64'hD4D4_C3C3_B2B2_A1A1, "R4 split write");
    run(1'b0, 32'h00206, 3, 2'b11, 64'h0, "R4 split read");
  endtask
  task automatic t_bytes();
    run(1'b1, 32'h00100, 1, 2'b01, 64'h0000_0000_FF77_FF55, "R9 low lane write");
    run(1'b1, 32'h00102, 0, 2'b10, 64'h0000_0000_0000_99FF, "R9 high lane write");
    run(1'b0, 32'h00100, 3, 2'b11, 64'h0, "R9 full read");
    run(1'b0, 32'h00100, 3, 2'b10, 64'h0, "R9 upper-only read");
  endtask
  task automatic t_wrap();
    run(1'b1, 32'h1FFFE, 3, 2'b11, 64'h0D0D_0C0C_0B0B_0A0A, "R4 wrap write");
    run(1'b0, 32'h1FFFE, 3, 2'b11, 64'h0, "R4 wrap read");
  endtask
  task automatic t_busy();
    fork
      run(1'b0, 32'h00100, 3, 2'b11, 64'h0, "R10 busy read");
      begin
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00300;
        req_len = 2'd0; req_bmask = 2'b11; req_wdata = 64'h5A5A;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (10) @(negedge clk);
    chk(!mem.exists(32'h300), "R10", "request while busy taken", int'(mem.exists(32'h300)), 0);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_write();
    t_page_read();
    t_single_read();
    t_mid_read();
    t_cross();
    t_bytes();
    t_wrap();
    t_busy();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule